// File: doc/BRIEF.md
# HDB3 Line Decoder with Code-Violation Flag

This block turns a received dual-rail bipolar stream into single-rail NRZ data. Two input lines carry positive and negative marks, and both are sampled on the recovered receive clock. The decoder records the polarity of the last mark. When a mark has the same polarity as that last mark, it is a violation. A violation preceded by two empty samples ends a zero-substitution code, either B00V or 000V. The decoder then restores the whole four-bit code to zeros. It does this inside a four-stage delay line, before the substituted marks reach the output.

Any other violation raises a one-clock line-code-violation pulse. So does a mark present on both rails at once, and so does a run of four empty samples. A static bypass input switches the substitution removal and the violation flag off. The mark stream then passes through with the same latency.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: While reset is asserted, `data_o` and `lcv_o` are 0. Reset clears the polarity history, the zero-run count and the delay line. The first mark after reset, of either polarity, is therefore never treated as a violation.
- R2: A sample is a mark when `pos_i` or `neg_i` is 1. When no substitution applies, a sample driven in cycle k appears on `data_o` in cycle k+4, as 1 for a mark and 0 for an empty sample.
- R3: The pattern B00V is a mark, two empty samples, then a mark of the same polarity as B. It appears on `data_o` as four zeros and does not raise `lcv_o`, for either polarity of B.
- R4: The pattern 000V is three empty samples, then a mark of the same polarity as the last earlier mark. It appears on `data_o` as four zeros and does not raise `lcv_o`.
- R5: Take a single-rail mark with the same polarity as the last mark where at least one of the two samples before it was a mark. The decoder sets `lcv_o` to 1 in cycle k+1 for exactly one cycle and outputs the mark as a 1.
- R6: When both rails are 1 in cycle k, `lcv_o` is 1 in cycle k+1 and the sample is output as a 1. The polarity history stays unchanged.
- R7: The fourth consecutive empty sample (cycle k) gives `lcv_o` = 1 in cycle k+1. Further empty samples give no more pulses until a mark arrives.
- R8: While `bypass_i` is 1, `data_o` in cycle k+4 equals `pos_i | neg_i` of cycle k, with no substitution removal, and `lcv_o` stays 0.
- R9: The polarity history also updates on violations. A mark opposite to the previous violation is a normal mark. Back-to-back substitution codes are each restored to zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | 1 = pass marks through undecoded, flag suppressed |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| data_o | output | 1 | Decoded NRZ data, four cycles behind the rails |
| lcv_o | output | 1 | One-cycle line-code-violation pulse |

## Verification
The hardest state to reach is the polarity history at a given moment. It is hidden, and both legal and illegal violations depend on it. To reach it, each scenario starts from reset and first sends a known mark, so every later violation is set by the stimulus string alone. A check that reset clears the history drives a stream that ends on a negative mark, resets, and then starts with a negative mark. A stale history would turn that first mark into a removed violation and show up as a missing 1 four cycles later. Back-to-back codes and a both-rails mark placed just before an opposite mark test that the history moves only on single-rail marks.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_POS  = 2'b01,
        POL_NEG  = 2'b10
    } pol_e;

    typedef struct packed {
        logic mark;    // either rail active
        logic dual;    // both rails active
        logic same;    // single-rail mark matching last polarity
        logic gap_ok;  // preceding samples were all empty
    } sample_t;

endpackage

// File: rtl/hdb3_pol_track.sv
module hdb3_pol_track
    import hdb3_pkg::*;
#(
    parameter int GAP = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pos_i,
    input  logic    neg_i,
    output sample_t cls_o
);

    typedef struct packed {
        pol_e           pol;
        logic [GAP-1:0] raw;
    } trk_s;

    trk_s trk_d, trk_q;
    pol_e cur_pol;

    always_comb begin
        trk_d = trk_q;
        cls_o = '0;

        if (pos_i && !neg_i)      cur_pol = POL_POS;
        else if (neg_i && !pos_i) cur_pol = POL_NEG;
        else                      cur_pol = POL_NONE;

        cls_o.mark   = pos_i | neg_i;
        cls_o.dual   = pos_i & neg_i;
        cls_o.same   = (cur_pol != POL_NONE) && (trk_q.pol != POL_NONE)
                       && (cur_pol == trk_q.pol);
        cls_o.gap_ok = (trk_q.raw == '0);

        if (cur_pol != POL_NONE) trk_d.pol = cur_pol;
        trk_d.raw = {trk_q.raw[GAP-2:0], cls_o.mark};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{pol: POL_NONE, raw: '0};
        else        trk_q <= trk_d;
    end

    // R9: once a polarity is learned it is never forgotten
    p_pol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.pol != POL_NONE) |=> (trk_q.pol != POL_NONE));

    // R6: a both-rail sample leaves the history as it was
    p_dual_keeps_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && neg_i) |=> $stable(trk_q.pol));

    p_pol_encoding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.pol != 2'b11);

endmodule

// File: rtl/hdb3_zero_run.sv
module hdb3_zero_run #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    output logic hit_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_s;

    run_s run_d, run_q;

    always_comb begin
        run_d = run_q;
        hit_o = !mark_i && (run_q.cnt == LIM_M1);
        if (mark_i)                run_d.cnt = '0;
        else if (run_q.cnt != LIM_V) run_d.cnt = run_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.cnt <= LIM_V);

    // R7: after the flagged zero the counter parks at the limit
    p_hit_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (run_q.cnt == LIM_V));

endmodule

// File: rtl/hdb3_delay_line.sv
module hdb3_delay_line #(
    parameter int DEPTH   = 4,
    parameter int CLR_IDX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic clr_i,
    output logic bit_o
);

    typedef struct packed {
        logic [DEPTH-1:0] dl;
    } line_s;

    line_s line_d, line_q;

    always_comb begin
        line_d = line_q;
        line_d.dl[0] = bit_i;
        for (int i = 1; i < DEPTH; i++) begin
            if (clr_i && (i - 1 == CLR_IDX)) line_d.dl[i] = 1'b0;
            else                             line_d.dl[i] = line_q.dl[i-1];
        end
    end

    assign bit_o = line_q.dl[DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // R3: the cleared pulse position is empty one stage later
    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (line_q.dl[CLR_IDX+1] == 1'b0));

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
    import hdb3_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ZRUN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_i,
    input  logic pos_i,
    input  logic neg_i,
    output logic data_o,
    output logic lcv_o
);

    localparam int SPAN    = 4;
    localparam int GAP     = SPAN - 2;
    localparam int CLR_IDX = SPAN - 2;

    typedef struct packed {
        logic lcv;
    } top_s;

    sample_t cls;
    logic    run_hit;
    logic    viol_ok;
    logic    viol_bad;
    logic    ins_bit;
    top_s    top_d, top_q;

    hdb3_pol_track #(.GAP(GAP)) u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (pos_i),
        .neg_i (neg_i),
        .cls_o (cls)
    );

    hdb3_zero_run #(.LIMIT(ZRUN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .mark_i (cls.mark),
        .hit_o  (run_hit)
    );

    always_comb begin
        top_d    = top_q;
        viol_ok  = !bypass_i && cls.same && cls.gap_ok;
        viol_bad = !bypass_i && ((cls.same && !cls.gap_ok) || cls.dual);
        ins_bit  = cls.mark && !viol_ok;
        top_d.lcv = viol_bad || (run_hit && !bypass_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    hdb3_delay_line #(.DEPTH(DEPTH), .CLR_IDX(CLR_IDX)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (ins_bit),
        .clr_i (viol_ok),
        .bit_o (data_o)
    );

    assign lcv_o = top_q.lcv;

    p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> !lcv_o);

    p_dual_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && neg_i && !bypass_i) |=> lcv_o);

    // R5: a same-polarity mark right after another mark is flagged
    p_adjacent_viol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls.same && !bypass_i && $past(pos_i || neg_i)) |=> lcv_o);

endmodule

// File: tb/hdb3_rx_decoder_bench.sv
module hdb3_rx_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic pos = 1'b0;
    logic neg = 1'b0;
    logic data_o;
    logic lcv_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic hist_d [0:1023];
    logic hist_l [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdb3_rx_decoder u_hdb3_rx_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (bypass),
        .pos_i    (pos),
        .neg_i    (neg),
        .data_o   (data_o),
        .lcv_o    (lcv_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // P = positive mark, N = negative mark, D = both rails, 0 = empty
    task automatic tick(input byte c);
        @(negedge clk);
        hist_d[cyc] = data_o;
        hist_l[cyc] = lcv_o;
        rst_n = 1'b1;
        pos = (c == "P") || (c == "D");
        neg = (c == "N") || (c == "D");
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pos = 1'b0;
        neg = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "data_o in reset", data_o, 1'b0);
        chk("R1", "lcv_o in reset", lcv_o, 1'b0);
    endtask

    // data expected at cycle base+i+4, lcv at base+i+1
    task automatic run_case(input string req, input string stim,
                            input string exp_d, input string exp_l);
        int base;
        base = cyc;
        for (int i = 0; i < stim.len(); i++) tick(stim[i]);
        for (int i = 0; i < exp_d.len(); i++)
            chk(req, $sformatf("%s data[%0d]", stim, i), hist_d[base+i+4], exp_d[i] == "1");
        for (int i = 0; i < exp_l.len(); i++)
            chk(req, $sformatf("%s lcv[%0d]", stim, i), hist_l[base+i+1], exp_l[i] == "1");
    endtask

    task automatic t_reset_state();
        do_reset();
        run_case("R2", "PNPN", "", "000");
        // R1: a stale negative history would remove the first N
        do_reset();
        run_case("R1", "N0P0NPNP", "1010", "0000000");
    endtask

    task automatic t_plain_latency();
        do_reset();
        run_case("R2", "P0N00PNP0NPN", "10100111", "00000000000");
    endtask

    task automatic t_b00v();
        do_reset();
        run_case("R3", "PN00NPNPN", "10000", "00000000");
        do_reset();
        run_case("R3", "NP00PNPNP", "10000", "00000000");
    endtask

    task automatic t_000v();
        do_reset();
        run_case("R4", "P000PNPNP", "10000", "00000000");
        do_reset();
        run_case("R9", "P000PN00NPNPN", "100000000", "000000000000");
    endtask

    task automatic t_illegal();
        do_reset();
        run_case("R5", "PNN0PNPNP", "11101", "00100000");
        do_reset();
        run_case("R5", "PN0NPNPNP", "11011", "00010000");
    endtask

    task automatic t_dual();
        do_reset();
        run_case("R6", "PDNPNPNP", "1111", "0100000");
    endtask

    task automatic t_zero_run();
        do_reset();
        run_case("R7", "P00000000NPNPN", "1000000001", "0000100000000");
        do_reset();
        run_case("R7", "0000PNPNP", "00001", "00010000");
    endtask

    task automatic t_bypass();
        bypass = 1'b1;
        do_reset();
        run_case("R8", "PN00NPNN0000DPNPN", "1100111100001", "0000000000000000");
        bypass = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_plain_latency();
        t_b00v();
        t_000v();
        t_illegal();
        t_dual();
        t_zero_run();
        t_bypass();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL all-requirements watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule